// File: doc/BRIEF.md
# Display Test Pattern Generator

This block sits in a display pixel pipeline and, when enabled, replaces the incoming video with a synthetic image. The image covers a programmable active rectangle. The upstream timing logic supplies the current pixel column and line, an active-region qualifier and a start-of-frame strobe. A small register port sets the pattern. The patterns are an eight-colour square grid, two-colour vertical or horizontal bars, a single horizontal ramp, and a dual ramp whose lower half uses a different slope. Tile and step sizes are powers of two. Every output component is a 16-bit MSB-aligned value that is truncated to the chosen bit depth.

Register writes land in a shadow copy. The shadow copy becomes live on the next start-of-frame strobe, so a frame never changes pattern part way through. A pending flag shows that a written update has not yet taken effect. A blanked flag shows that the generator is both live and settled. When the generator is disabled, the video input passes through to the output.

Top module: `tpg_top`

## Requirements
- R1: After a synchronous active-low reset, the three colour outputs, `upd_pending` and `gen_blanked` are all zero, and the generator is disabled.
- R2: When the effective configuration has enable = 0, each colour output equals the matching video input from one clock earlier.
- R3: A write to `cfg_addr`, at any address, goes into the shadow copy and sets `upd_pending` from the next cycle on. On a cycle where `pix_sof` is high, the shadow copy as it stood before that cycle's write is used for that pixel and becomes live, and `upd_pending` clears unless a write happens in the same cycle. Register map:
  - Address 0 (control): bit 0 enable, bits 3:1 mode, bit 4 limited range, bits 6:5 depth, bits 10:7 horizontal exponent H, bits 14:11 vertical exponent V.
  - Address 1: width in bits 15:0, height in bits 31:16.
  - Addresses 2, 3 and 4: the R, G and B colours, with colour0 in bits 15:0 and colour1 in bits 31:16.
  - Address 5: ramp offset in bits 15:0, INC0 in bits 20:16, INC1 in bits 25:21.
- R4: In mode 1 (vertical bars), a pixel takes colour0 when bit 0 of (x >> H) is 0 and colour1 otherwise.
- R5: In mode 2 (horizontal bars), the choice between colour0 and colour1 follows bit 0 of (y >> V) in the same way.
- R6: In mode 0 (squares), let idx = ((x >> H) + (y >> V)) mod 8. The R component is high when idx bit 2 is set, G when idx bit 1 is set, and B when idx bit 0 is set. The levels are 0xFFFF/0x0000 at full range and 0xEB00/0x1000 at limited range.
- R7: In mode 3 (single ramp), every component equals offset + (x >> H) * 2^INC0, saturating at 0xFFFF.
- R8: Mode 4 (dual ramp) follows R7, except that lines with y >= height/2 (integer division) use INC1.
- R9: Pattern outputs keep only the top bits for the depth code: 0 keeps 6 bits, 1 keeps 8, 2 keeps 10 and 3 keeps 12. Colour registers always hold 0 in bits 3:0 of each colour.
- R10: While the generator is enabled, a pixel outside the region (`pix_active` low, x >= width or y >= height) outputs zero on all components.
- R11: `gen_blanked` is high exactly when the live enable is 1 and `upd_pending` is 0.
- R12: Mode codes 5 to 7 output colour0 across the whole region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_x | input | 16 | Current pixel column |
| pix_y | input | 16 | Current line |
| pix_active | input | 1 | Pixel lies in the active display area |
| pix_sof | input | 1 | Start-of-frame strobe; applies the shadow copy |
| vid_r | input | 16 | Incoming video, R/Cr |
| vid_g | input | 16 | Incoming video, G/Y |
| vid_b | input | 16 | Incoming video, B/Cb |
| out_r | output | 16 | Output pixel, R/Cr |
| out_g | output | 16 | Output pixel, G/Y |
| out_b | output | 16 | Output pixel, B/Cb |
| upd_pending | output | 1 | Shadow update not yet applied |
| gen_blanked | output | 1 | Generator live with no pending update |

## Verification
Each colour output is registered once, so a pixel presented at one rising edge appears on `out_r/g/b` after that edge and before the next one. `upd_pending` and `gen_blanked` reflect the register state captured at that same edge. The bench drives inputs on the falling edge. At the next falling edge it compares all five outputs against a prediction that its behavioural model made when those inputs were applied, so every comparison lands exactly one edge after its stimulus. The model keeps raw shadow and live register words and applies the same-cycle rules for start of frame and writes, so the pending and blanked checks follow the same one-edge schedule.

// File: rtl/tpg_pkg.sv
// Shared constants, register map and configuration record for the
// test pattern generator. Assumes 16-bit MSB-aligned colour components.
package tpg_pkg;

    localparam int POS_W  = 16;
    localparam int COL_W  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 3;
    localparam int EXP_W  = 4;
    localparam int INC_W  = 5;
    localparam int N_COMP = 3;   // index 0 = R/Cr, 1 = G/Y, 2 = B/Cb
    localparam int RAMP_W = POS_W + (1 << INC_W) + 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_SIZE = 3'd1;
    localparam logic [ADDR_W-1:0] A_COLR = 3'd2;
    localparam logic [ADDR_W-1:0] A_COLG = 3'd3;
    localparam logic [ADDR_W-1:0] A_COLB = 3'd4;
    localparam logic [ADDR_W-1:0] A_RAMP = 3'd5;

    localparam logic [COL_W-1:0] NIB_CLR  = 16'hFFF0;
    localparam logic [COL_W-1:0] FULL_HI  = 16'hFFFF;
    localparam logic [COL_W-1:0] FULL_LO  = 16'h0000;
    localparam logic [COL_W-1:0] LIM_HI   = 16'hEB00;
    localparam logic [COL_W-1:0] LIM_LO   = 16'h1000;

    typedef enum logic [2:0] {
        PM_SQUARES = 3'd0,
        PM_VBARS   = 3'd1,
        PM_HBARS   = 3'd2,
        PM_RAMP1   = 3'd3,
        PM_RAMP2   = 3'd4
    } pat_mode_e;

    typedef struct packed {
        logic                         en;
        logic [2:0]                   mode;
        logic                         lim;
        logic [1:0]                   depth;
        logic [EXP_W-1:0]             hexp;
        logic [EXP_W-1:0]             vexp;
        logic [POS_W-1:0]             width;
        logic [POS_W-1:0]             height;
        logic [N_COMP-1:0][COL_W-1:0] col0;
        logic [N_COMP-1:0][COL_W-1:0] col1;
        logic [COL_W-1:0]             ramp_off;
        logic [INC_W-1:0]             inc0;
        logic [INC_W-1:0]             inc1;
    } tpg_cfg_t;

    // Mask that keeps the top bits of a component for a depth code.
    function automatic logic [COL_W-1:0] depth_mask(input logic [1:0] code);
        case (code)
            2'd0:    depth_mask = 16'hFC00;
            2'd1:    depth_mask = 16'hFF00;
            2'd2:    depth_mask = 16'hFFC0;
            default: depth_mask = 16'hFFF0;
        endcase
    endfunction

endpackage

// File: rtl/tpg_cfg_regs.sv
// Shadow and live configuration registers for the pattern generator.
// Writes land in the shadow copy; the start-of-frame strobe moves the
// shadow copy (as it stood before any same-cycle write) into the live copy.
// The effective configuration seen by the pixel path is the shadow copy on
// a start-of-frame cycle and the live copy otherwise.
module tpg_cfg_regs
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              pix_sof,
    output tpg_cfg_t          eff_cfg,
    output logic              live_en,
    output logic              pending
);

    tpg_cfg_t shadow_q, live_q, shadow_d;

    // Decode a write into the next shadow value.
    always_comb begin
        shadow_d = shadow_q;
        if (cfg_we) begin
            case (cfg_addr)
                A_CTRL: begin
                    shadow_d.en    = cfg_wdata[0];
                    shadow_d.mode  = cfg_wdata[3:1];
                    shadow_d.lim   = cfg_wdata[4];
                    shadow_d.depth = cfg_wdata[6:5];
                    shadow_d.hexp  = cfg_wdata[10:7];
                    shadow_d.vexp  = cfg_wdata[14:11];
                end
                A_SIZE: begin
                    shadow_d.width  = cfg_wdata[15:0];
                    shadow_d.height = cfg_wdata[31:16];
                end
                A_COLR, A_COLG, A_COLB: begin
                    shadow_d.col0[cfg_addr - A_COLR] = cfg_wdata[15:0] & NIB_CLR;
                    shadow_d.col1[cfg_addr - A_COLR] = cfg_wdata[31:16] & NIB_CLR;
                end
                A_RAMP: begin
                    shadow_d.ramp_off = cfg_wdata[15:0];
                    shadow_d.inc0     = cfg_wdata[20:16];
                    shadow_d.inc1     = cfg_wdata[25:21];
                end
                default: ;
            endcase
        end
    end

    // Shadow copy, live copy and pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            live_q   <= '0;
            pending  <= 1'b0;
        end else begin
            shadow_q <= shadow_d;
            if (pix_sof) live_q <= shadow_q;
            if (cfg_we)       pending <= 1'b1;
            else if (pix_sof) pending <= 1'b0;
        end
    end

    // Effective configuration for the current pixel.
    always_comb begin
        eff_cfg = pix_sof ? shadow_q : live_q;
        live_en = live_q.en;
    end

    assert_pending_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> pending);
    assert_pending_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_sof && !cfg_we) |=> !pending);
    assert_live_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_sof |=> (live_q == $past(shadow_q)));

endmodule

// File: rtl/tpg_pixel.sv
// Combinational pattern computation for one pixel position.
// Assumes the configuration is stable for the cycle; produces a depth
// masked value per component and a region qualifier.
module tpg_pixel
    import tpg_pkg::*;
(
    input  tpg_cfg_t                     cfg,
    input  logic [POS_W-1:0]             pos_x,
    input  logic [POS_W-1:0]             pos_y,
    input  logic                         pos_act,
    output logic [N_COMP-1:0][COL_W-1:0] pix,
    output logic                         in_region
);

    logic [POS_W-1:0]  tile_x, tile_y;
    logic [2:0]        sq_idx;
    logic [INC_W-1:0]  inc_sel;
    logic [RAMP_W-1:0] ramp_sum;
    logic [COL_W-1:0]  ramp_val, lvl_hi, lvl_lo, dmask;

    // Tile coordinates, region test and square colour index.
    always_comb begin
        tile_x    = pos_x >> cfg.hexp;
        tile_y    = pos_y >> cfg.vexp;
        sq_idx    = tile_x[2:0] + tile_y[2:0];
        in_region = pos_act && (pos_x < cfg.width) && (pos_y < cfg.height);
        lvl_hi    = cfg.lim ? LIM_HI : FULL_HI;
        lvl_lo    = cfg.lim ? LIM_LO : FULL_LO;
        dmask     = depth_mask(cfg.depth);
    end

    // Ramp with slope chosen by half of the region, saturating at full scale.
    always_comb begin
        inc_sel  = (cfg.mode == PM_RAMP2 && pos_y >= (cfg.height >> 1)) ? cfg.inc1 : cfg.inc0;
        ramp_sum = RAMP_W'(cfg.ramp_off) + (RAMP_W'(tile_x) << inc_sel);
        ramp_val = (|ramp_sum[RAMP_W-1:COL_W]) ? FULL_HI : ramp_sum[COL_W-1:0];
    end

    for (genvar k = 0; k < N_COMP; k++) begin : g_comp
        logic [COL_W-1:0] raw;
        // Per-component pattern select.
        always_comb begin
            case (cfg.mode)
                PM_SQUARES: raw = sq_idx[N_COMP-1-k] ? lvl_hi : lvl_lo;
                PM_VBARS:   raw = tile_x[0] ? cfg.col1[k] : cfg.col0[k];
                PM_HBARS:   raw = tile_y[0] ? cfg.col1[k] : cfg.col0[k];
                PM_RAMP1,
                PM_RAMP2:   raw = ramp_val;
                default:    raw = cfg.col0[k];
            endcase
            pix[k] = raw & dmask;
        end
    end

endmodule

// File: rtl/tpg_top.sv
// Display test pattern generator top level. Selects, per pixel, between
// pass-through video, black outside the region and the generated pattern,
// and registers the result (one cycle latency). Assumes the pixel inputs
// and the start-of-frame strobe come from an upstream timing generator.
module tpg_top
    import tpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [POS_W-1:0]  pix_x,
    input  logic [POS_W-1:0]  pix_y,
    input  logic              pix_active,
    input  logic              pix_sof,
    input  logic [COL_W-1:0]  vid_r,
    input  logic [COL_W-1:0]  vid_g,
    input  logic [COL_W-1:0]  vid_b,
    output logic [COL_W-1:0]  out_r,
    output logic [COL_W-1:0]  out_g,
    output logic [COL_W-1:0]  out_b,
    output logic              upd_pending,
    output logic              gen_blanked
);

    tpg_cfg_t                     eff_cfg;
    logic                         live_en;
    logic [N_COMP-1:0][COL_W-1:0] pat_pix, vid_in, out_q;
    logic                         in_region;

    tpg_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pix_sof   (pix_sof),
        .eff_cfg   (eff_cfg),
        .live_en   (live_en),
        .pending   (upd_pending)
    );

    tpg_pixel u_pixel (
        .cfg       (eff_cfg),
        .pos_x     (pix_x),
        .pos_y     (pix_y),
        .pos_act   (pix_active),
        .pix       (pat_pix),
        .in_region (in_region)
    );

    // Gather the video input into component order.
    always_comb begin
        vid_in = {vid_b, vid_g, vid_r};
    end

    // Output register: pass-through, black or pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)              out_q <= '0;
        else if (!eff_cfg.en)    out_q <= vid_in;
        else if (!in_region)     out_q <= '0;
        else                     out_q <= pat_pix;
    end

    // Drive ports and the blanked flag.
    always_comb begin
        out_r       = out_q[0];
        out_g       = out_q[1];
        out_b       = out_q[2];
        gen_blanked = live_en && !upd_pending;
    end

    assert_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !eff_cfg.en |=> (out_r == $past(vid_r) && out_g == $past(vid_g) && out_b == $past(vid_b)));
    assert_outside_black_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_cfg.en && !pix_active) |=> (out_r == '0 && out_g == '0 && out_b == '0));
    assert_low_nibble_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eff_cfg.en |=> (out_r[3:0] == 4'h0 && out_g[3:0] == 4'h0 && out_b[3:0] == 4'h0));

endmodule

// File: tb/tpg_top_tb.sv
// Bench for tpg_top: behavioural reference model over raw register words,
// outputs compared at every falling edge against the prediction made one
// edge earlier.
module tpg_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [15:0] px = '0, py = '0;
    logic        pact = 1'b0, psof = 1'b0;
    logic [15:0] vid_r = '0, vid_g = '0, vid_b = '0;
    logic [15:0] out_r, out_g, out_b;
    logic        upd_pending, gen_blanked;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    bit [31:0] shd [6];
    bit [31:0] act [6];
    bit        pend = 1'b0;
    int        exp_c [3];
    bit        exp_pend = 1'b0, exp_blk = 1'b0;
    string     exp_tag = "R1";

    always #5 clk = ~clk;

    tpg_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
        .pix_x(px), .pix_y(py), .pix_active(pact), .pix_sof(psof),
        .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b),
        .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .upd_pending(upd_pending), .gen_blanked(gen_blanked)
    );

    task automatic chk(input string tag, input string what, input int actual, input int expected);
        nchk++;
        if (actual != expected) begin
            nfail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, actual, expected);
        end
    endtask

    task automatic compare();
        chk(exp_tag, "out_r", int'(out_r), exp_c[0]);
        chk(exp_tag, "out_g", int'(out_g), exp_c[1]);
        chk(exp_tag, "out_b", int'(out_b), exp_c[2]);
        chk("R3", "upd_pending", int'(upd_pending), int'(exp_pend));
        chk("R11", "gen_blanked", int'(gen_blanked), int'(exp_blk));
    endtask

    // Predict the outputs for the stimulus now on the pins, then advance state.
    task automatic model_step();
        bit [31:0] e [6];
        int hr, vr, wid, hei, mode, dep, msk, x, y, tx, ty, idx, inc, hi, lo;
        longint rv;
        for (int i = 0; i < 6; i++) e[i] = psof ? shd[i] : act[i];
        x = int'(px); y = int'(py);
        mode = int'(e[0][3:1]); dep = int'(e[0][6:5]);
        hr = int'(e[0][10:7]); vr = int'(e[0][14:11]);
        wid = int'(e[1][15:0]); hei = int'(e[1][31:16]);
        msk = (dep == 0) ? 'hFC00 : (dep == 1) ? 'hFF00 : (dep == 2) ? 'hFFC0 : 'hFFF0;
        tx = x >> hr; ty = y >> vr;
        if (!e[0][0]) begin
            exp_tag = "R2";
            exp_c[0] = int'(vid_r); exp_c[1] = int'(vid_g); exp_c[2] = int'(vid_b);
        end else if (!(pact && x < wid && y < hei)) begin
            exp_tag = "R10";
            for (int k = 0; k < 3; k++) exp_c[k] = 0;
        end else begin
            for (int k = 0; k < 3; k++) begin
                int c0, c1, v;
                c0 = int'(e[2+k][15:0]); c1 = int'(e[2+k][31:16]);
                case (mode)
                    0: begin
                        exp_tag = "R6/R9";
                        idx = (tx + ty) % 8;
                        hi = e[0][4] ? 'hEB00 : 'hFFFF;
                        lo = e[0][4] ? 'h1000 : 0;
                        v = ((idx >> (2 - k)) % 2 == 1) ? hi : lo;
                    end
                    1: begin exp_tag = "R4/R9"; v = (tx % 2 == 1) ? c1 : c0; end
                    2: begin exp_tag = "R5/R9"; v = (ty % 2 == 1) ? c1 : c0; end
                    3, 4: begin
                        exp_tag = (mode == 3) ? "R7/R9" : "R8/R9";
                        inc = (mode == 4 && y >= hei / 2) ? int'(e[5][25:21]) : int'(e[5][20:16]);
                        rv = longint'(e[5][15:0]) + (longint'(tx) << inc);
                        v = (rv > 65535) ? 'hFFFF : int'(rv);
                    end
                    default: begin exp_tag = "R12/R9"; v = c0; end
                endcase
                exp_c[k] = v & msk;
            end
        end
        if (psof) for (int i = 0; i < 6; i++) act[i] = shd[i];
        if (we) begin
            if (addr >= 2 && addr <= 4) shd[addr] = wdata & 32'hFFF0FFF0;
            else if (addr <= 5) shd[addr] = wdata;
            pend = 1'b1;
        end else if (psof) pend = 1'b0;
        exp_pend = pend;
        exp_blk = act[0][0] && !pend;
    endtask

    task automatic tick(input bit w, input int a, input bit [31:0] d,
                        input int x, input int y, input bit ac, input bit sof);
        @(negedge clk);
        compare();
        we = w; addr = 3'(a); wdata = d;
        px = 16'(x); py = 16'(y); pact = ac; psof = sof;
        vid_r = 16'(x * 311 + y * 17 + 5);
        vid_g = 16'(x * 7919 + 3);
        vid_b = 16'(y * 4099 + x);
        model_step();
    endtask

    task automatic wr(input int a, input bit [31:0] d);
        tick(1'b1, a, d, 0, 0, 1'b0, 1'b0);
    endtask

    task automatic frame(input int xt, input int yt, input int xa);
        for (int y = 0; y < yt; y++)
            for (int x = 0; x < xt; x++)
                tick(1'b0, 0, 0, x, y, x < xa, (x == 0 && y == 0));
    endtask

    function automatic bit [31:0] ctl(input int en, input int mode, input int lim,
                                      input int dep, input int hr, input int vr);
        return 32'(en + (mode << 1) + (lim << 4) + (dep << 5) + (hr << 7) + (vr << 11));
    endfunction

    initial begin
        for (int i = 0; i < 6; i++) begin shd[i] = '0; act[i] = '0; end
        for (int k = 0; k < 3; k++) exp_c[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state is checked by the first comparison; R2 pass-through follows.
        for (int i = 0; i < 6; i++) tick(1'b0, 0, 0, i, 1, 1'b1, 1'b0);
        // R3: writes stay in the shadow copy until start of frame.
        wr(1, {16'd6, 16'd24});
        wr(2, 32'h1234_ABCD);
        wr(3, 32'hF00F_0FF0);
        wr(4, 32'h5A5A_A5A5);
        wr(0, ctl(1, 1, 0, 3, 2, 0));
        frame(4, 1, 4);
        // R4 vertical bars, 12-bit.
        frame(28, 7, 26);
        // R5 horizontal bars, 8-bit.
        wr(0, ctl(1, 2, 0, 1, 0, 1));
        frame(26, 8, 26);
        // R6 squares, full range 10-bit, then limited range 6-bit.
        wr(0, ctl(1, 0, 0, 2, 2, 1));
        frame(36, 8, 34);
        wr(0, ctl(1, 0, 1, 0, 1, 0));
        frame(20, 8, 20);
        // R7 single ramp with saturation.
        wr(5, {6'd0, 5'd9, 5'd12, 16'h0100});
        wr(0, ctl(1, 3, 0, 3, 1, 0));
        frame(40, 3, 40);
        wr(5, {6'd0, 5'd2, 5'd3, 16'hFFF8});
        frame(10, 2, 10);
        // R8 dual ramp: lower half uses INC1.
        wr(5, {6'd0, 5'd11, 5'd4, 16'h0040});
        wr(0, ctl(1, 4, 0, 2, 0, 0));
        frame(26, 7, 26);
        // R12 unused mode codes give colour0.
        wr(0, ctl(1, 6, 0, 1, 0, 0));
        frame(10, 3, 10);
        // R3 write in the same cycle as start of frame keeps pending set.
        tick(1'b1, 0, ctl(1, 1, 0, 0, 0, 0), 0, 0, 1'b1, 1'b1);
        tick(1'b0, 0, 0, 1, 0, 1'b1, 1'b0);
        frame(12, 2, 12);
        // R3/R2 zero control disables at the next frame.
        wr(0, 32'h0);
        frame(8, 2, 8);
        tick(1'b0, 0, 0, 0, 0, 1'b0, 1'b0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog R1: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule